// File: doc/BRIEF.md
# Test Access Path Selector

This block is the routing switch of a digital line test access point that sits between two line directions, E and F. Each direction has an incoming and an outgoing serial bit stream. A mode code chooses what each outgoing line carries: the other direction's incoming stream, the same direction's incoming stream looped back, the output of a test signal generator, or a quasi-random idle source. The same code chooses which incoming stream reaches the signal presence detector.

The block carries `W` bits per clock on every stream, so one bit per cycle is the serial case. The mode is decoded and all routing is muxed combinationally. The results are captured in one register stage, which makes every output change exactly one clock after the inputs that cause it, with no glitch between sources. In the two full-loop modes, a status flag marks the incoming line that is cut off and terminated. The asynchronous active-low reset is released through a local synchronizer.

Top module: `tap_route_sel`

## Requirements
- R1: While reset is active, and until the first clock edge after the internal synchronizer has released it, all five outputs are 0.
- R2: With mode code 0 (through), E outgoing carries F incoming, F outgoing carries E incoming, the detector gets E incoming, and both terminate flags are 0.
- R3: With mode code 1 (split E, loop F), the detector gets E incoming, E outgoing carries the generator, F outgoing carries F incoming, and both flags are 0.
- R4: With mode code 2 (split F, loop E), the detector gets F incoming, F outgoing carries the generator, E outgoing carries E incoming, and both flags are 0.
- R5: With mode code 3 (loop E), the detector gets E incoming, E outgoing carries E incoming, F outgoing carries the quasi-random source, the F terminate flag is 1 and the E flag is 0.
- R6: With mode code 4 (loop F), the detector gets F incoming, F outgoing carries F incoming, E outgoing carries the quasi-random source, the E terminate flag is 1 and the F flag is 0.
- R7: Mode codes 5, 6 and 7 behave exactly as code 0.
- R8: Every output shows the mode and data sampled at the previous rising clock edge. A mode change made between edges does not alter any output until the next edge.
- R9: In loop-E mode, changing F incoming has no effect on any output.
- R10: At most one terminate flag is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Routing mode code (0..4, others as 0) |
| e_rx_i | input | W | E incoming stream |
| f_rx_i | input | W | F incoming stream |
| gen_i | input | W | Test signal generator output |
| qrs_i | input | W | Quasi-random idle source |
| e_tx_o | output | W | E outgoing stream |
| f_tx_o | output | W | F outgoing stream |
| det_o | output | W | Signal presence detector input |
| e_term_o | output | 1 | E incoming is terminated (loop F) |
| f_term_o | output | 1 | F incoming is terminated (loop E) |

## Verification
On every cycle after reset, the assertions check that each output equals the source that the previous cycle's mode selects. They also check that fallback codes route like through mode, that the terminate flags are never both set, and that the outputs stay at zero while reset is held. Some behaviour only the bench scenarios can show. These are the exact release point of the reset synchronizer, a mode change between edges leaving the outputs untouched until the next edge, and a toggling terminated F line leaving every output unchanged in loop-E mode.

// File: rtl/tap_route_pkg.sv
package tap_route_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_THRU    = 3'd0,
    MD_SPLIT_E = 3'd1,
    MD_SPLIT_F = 3'd2,
    MD_LOOP_E  = 3'd3,
    MD_LOOP_F  = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    SRC_E_RX = 2'd0,
    SRC_F_RX = 2'd1,
    SRC_GEN  = 2'd2,
    SRC_QRS  = 2'd3
  } src_e;

  typedef struct packed {
    src_e e_tx;
    src_e f_tx;
    src_e det;
    logic e_term;
    logic f_term;
  } route_t;
endpackage

// File: rtl/tap_rst_sync.sv
module tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_d;
  logic [STAGES-1:0] sync_q;

  assign sync_d[0] = 1'b1;
  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    assign sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tap_mode_decode.sv
module tap_mode_decode
  import tap_route_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output route_t            route_o
);
  always_comb begin
    route_o = '{e_tx: SRC_F_RX, f_tx: SRC_E_RX, det: SRC_E_RX,
                e_term: 1'b0, f_term: 1'b0};
    case (mode_i)
      MD_SPLIT_E: begin
        route_o.e_tx = SRC_GEN;
        route_o.f_tx = SRC_F_RX;
        route_o.det  = SRC_E_RX;
      end
      MD_SPLIT_F: begin
        route_o.e_tx = SRC_E_RX;
        route_o.f_tx = SRC_GEN;
        route_o.det  = SRC_F_RX;
      end
      MD_LOOP_E: begin
        route_o.e_tx   = SRC_E_RX;
        route_o.f_tx   = SRC_QRS;
        route_o.det    = SRC_E_RX;
        route_o.f_term = 1'b1;
      end
      MD_LOOP_F: begin
        route_o.e_tx   = SRC_QRS;
        route_o.f_tx   = SRC_F_RX;
        route_o.det    = SRC_F_RX;
        route_o.e_term = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tap_src_mux.sv
module tap_src_mux
  import tap_route_pkg::*;
#(
  parameter int W = 1
) (
  input  src_e         sel_i,
  input  logic [W-1:0] e_rx_i,
  input  logic [W-1:0] f_rx_i,
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] qrs_i,
  output logic [W-1:0] out_o
);
  always_comb begin
    case (sel_i)
      SRC_E_RX: out_o = e_rx_i;
      SRC_F_RX: out_o = f_rx_i;
      SRC_GEN:  out_o = gen_i;
      default:  out_o = qrs_i;
    endcase
  end
endmodule

// File: rtl/tap_route_sel.sv
module tap_route_sel
  import tap_route_pkg::*;
#(
  parameter int W          = 1,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      e_rx_i,
  input  logic [W-1:0]      f_rx_i,
  input  logic [W-1:0]      gen_i,
  input  logic [W-1:0]      qrs_i,
  output logic [W-1:0]      e_tx_o,
  output logic [W-1:0]      f_tx_o,
  output logic [W-1:0]      det_o,
  output logic              e_term_o,
  output logic              f_term_o
);
  localparam int NUM_LANES = 3;

  logic                rst_sync_n;
  route_t              route;
  src_e                lane_sel [NUM_LANES];
  logic [W-1:0]        lane_d   [NUM_LANES];
  logic [W-1:0]        lane_q   [NUM_LANES];
  logic                e_term_d, f_term_d;
  logic                e_term_q, f_term_q;

  tap_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tap_mode_decode u_decode (
    .mode_i  (mode_i),
    .route_o (route)
  );

  assign lane_sel[0] = route.e_tx;
  assign lane_sel[1] = route.f_tx;
  assign lane_sel[2] = route.det;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    tap_src_mux #(.W(W)) u_mux (
      .sel_i  (lane_sel[l]),
      .e_rx_i (e_rx_i),
      .f_rx_i (f_rx_i),
      .gen_i  (gen_i),
      .qrs_i  (qrs_i),
      .out_o  (lane_d[l])
    );

    always_ff @(posedge clk_i or negedge rst_sync_n) begin
      if (!rst_sync_n) lane_q[l] <= '0;
      else             lane_q[l] <= lane_d[l];
    end
  end

  always_comb begin
    e_term_d = route.e_term;
    f_term_d = route.f_term;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      e_term_q <= 1'b0;
      f_term_q <= 1'b0;
    end else begin
      e_term_q <= e_term_d;
      f_term_q <= f_term_d;
    end
  end

  assign e_tx_o   = lane_q[0];
  assign f_tx_o   = lane_q[1];
  assign det_o    = lane_q[2];
  assign e_term_o = e_term_q;
  assign f_term_o = f_term_q;
endmodule

// File: rtl/tap_route_sel_chk.sv
module tap_route_sel_chk #(
  parameter int W = 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   mode_i,
  input logic [W-1:0] e_rx_i,
  input logic [W-1:0] f_rx_i,
  input logic [W-1:0] gen_i,
  input logic [W-1:0] qrs_i,
  input logic [W-1:0] e_tx_o,
  input logic [W-1:0] f_tx_o,
  input logic [W-1:0] det_o,
  input logic         e_term_o,
  input logic         f_term_o
);
  // R1: outputs held at zero while the synchronized reset is low
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_zero: assert (e_tx_o == '0 && f_tx_o == '0 && det_o == '0
                               && !e_term_o && !f_term_o)
        else $error("R1 outputs not zero in reset");
    end
  end

  a_r2_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0) |=> (e_tx_o == $past(f_rx_i) && f_tx_o == $past(e_rx_i)
                          && det_o == $past(e_rx_i) && !e_term_o && !f_term_o))
    else $error("R2 through routing");

  a_r3_split_e: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1) |=> (det_o == $past(e_rx_i) && e_tx_o == $past(gen_i)
                          && f_tx_o == $past(f_rx_i) && !e_term_o && !f_term_o))
    else $error("R3 split-E routing");

  a_r4_split_f: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2) |=> (det_o == $past(f_rx_i) && f_tx_o == $past(gen_i)
                          && e_tx_o == $past(e_rx_i) && !e_term_o && !f_term_o))
    else $error("R4 split-F routing");

  a_r5_loop_e: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd3) |=> (det_o == $past(e_rx_i) && e_tx_o == $past(e_rx_i)
                          && f_tx_o == $past(qrs_i) && !e_term_o && f_term_o))
    else $error("R5 loop-E routing");

  a_r6_loop_f: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4) |=> (det_o == $past(f_rx_i) && f_tx_o == $past(f_rx_i)
                          && e_tx_o == $past(qrs_i) && e_term_o && !f_term_o))
    else $error("R6 loop-F routing");

  a_r7_unused_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i > 3'd4) |=> (e_tx_o == $past(f_rx_i) && f_tx_o == $past(e_rx_i)
                         && det_o == $past(e_rx_i) && !e_term_o && !f_term_o))
    else $error("R7 unused code routing");

  a_r10_term_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({e_term_o, f_term_o}))
    else $error("R10 both terminate flags set");
endmodule

bind tap_route_sel tap_route_sel_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_sync_n),
  .mode_i   (mode_i),
  .e_rx_i   (e_rx_i),
  .f_rx_i   (f_rx_i),
  .gen_i    (gen_i),
  .qrs_i    (qrs_i),
  .e_tx_o   (e_tx_o),
  .f_tx_o   (f_tx_o),
  .det_o    (det_o),
  .e_term_o (e_term_o),
  .f_term_o (f_term_o)
);

// File: tb/tb_tap_route_sel.sv
module tb_tap_route_sel;
  // vector: [11:9] mode, [8] e_rx, [7] f_rx, [6] gen, [5] qrs,
  //         [4] e_tx, [3] f_tx, [2] det, [1] e_term, [0] f_term
  localparam int NVEC = 13;
  localparam logic [11:0] VEC [NVEC] = '{
    {3'd0, 4'b1000, 5'b01100},
    {3'd0, 4'b0111, 5'b10000},
    {3'd1, 4'b1001, 5'b00100},
    {3'd1, 4'b0110, 5'b11000},
    {3'd2, 4'b1001, 5'b10000},
    {3'd2, 4'b0110, 5'b01100},
    {3'd3, 4'b1010, 5'b10101},
    {3'd3, 4'b0101, 5'b01001},
    {3'd4, 4'b1001, 5'b10010},
    {3'd4, 4'b0110, 5'b01110},
    {3'd5, 4'b1011, 5'b01100},
    {3'd6, 4'b0100, 5'b10000},
    {3'd7, 4'b1100, 5'b11100}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode;
  logic       e_rx, f_rx, gen, qrs;
  logic       e_tx, f_tx, det, e_term, f_term;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  tap_route_sel dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .mode_i   (mode),
    .e_rx_i   (e_rx),
    .f_rx_i   (f_rx),
    .gen_i    (gen),
    .qrs_i    (qrs),
    .e_tx_o   (e_tx),
    .f_tx_o   (f_tx),
    .det_o    (det),
    .e_term_o (e_term),
    .f_term_o (f_term)
  );

  task automatic check(input string req, input string what,
                       input logic [4:0] got, input logic [4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(input logic [2:0] m, input logic [3:0] d);
    mode = m;
    {e_rx, f_rx, gen, qrs} = d;
  endtask

  initial begin
    rst_n = 1'b1;
    drive(3'd1, 4'b1010);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1", "outputs in reset", {e_tx, f_tx, det, e_term, f_term}, 5'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1
    check("R1", "first edge after release", {e_tx, f_tx, det, e_term, f_term}, 5'b0);
    @(posedge clk); #1
    check("R1", "second edge after release", {e_tx, f_tx, det, e_term, f_term}, 5'b0);
    @(posedge clk); #1
    check("R3", "first loaded edge", {e_tx, f_tx, det, e_term, f_term}, 5'b10100);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk) drive(VEC[i][11:9], VEC[i][8:5]);
      @(posedge clk); #1
      check(req_of(VEC[i][11:9]), "e_tx", {4'b0, e_tx}, {4'b0, VEC[i][4]});
      check(req_of(VEC[i][11:9]), "f_tx", {4'b0, f_tx}, {4'b0, VEC[i][3]});
      check(req_of(VEC[i][11:9]), "det", {4'b0, det}, {4'b0, VEC[i][2]});
      check(req_of(VEC[i][11:9]), "terms", {3'b0, e_term, f_term},
            {3'b0, VEC[i][1:0]});
      check("R10", "flags one-hot-or-zero", {4'b0, (e_term & f_term)}, 5'b0);
    end

    // R8: mode change between edges is invisible until the next edge
    @(negedge clk) drive(3'd3, 4'b1000);
    @(posedge clk); #1
    check("R8", "loop-E settled", {e_tx, f_tx, det, e_term, f_term}, 5'b10101);
    @(negedge clk) drive(3'd4, 4'b1001);
    #1 check("R8", "before edge", {e_tx, f_tx, det, e_term, f_term}, 5'b10101);
    @(posedge clk); #1
    check("R8", "after edge", {e_tx, f_tx, det, e_term, f_term}, 5'b10010);

    // R9: terminated F line toggling in loop-E has no effect
    @(negedge clk) drive(3'd3, 4'b1000);
    @(posedge clk); #1
    check("R9", "loop-E baseline", {e_tx, f_tx, det, e_term, f_term}, 5'b10101);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) f_rx = ~f_rx;
      @(posedge clk); #1
      check("R9", "F toggled", {e_tx, f_tx, det, e_term, f_term}, 5'b10101);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule